// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which of three operating states a small microcontroller is in (running, idle and power-down) and drives the clock-gate enables and the core regulator enable that go with each state. The CPU signals a wait-for-interrupt with a one-cycle pulse. Whether that pulse leads to idle or to power-down depends on a software-owned power-down enable bit and on the set of latched wake flags. Power-down is refused while any flag is still pending, and the block drops only to idle instead.

Peripherals report wake events as one-cycle pulses. Each pulse sets a sticky flag that software clears by writing 1 to it. The watchdog flag can only be cleared inside a window that a three-key unlock sequence opens, and the next protected write closes that window again. Two software-written masks give the per-mode table: one chooses which clock domains keep running in idle, the other which keep running in power-down. Fixed allow-lists stop the CPU domain and the fast bus-side domains from ever running while the device is low. When a wake event arrives in power-down, the core regulator comes back first. The clocks stay gated for a fixed settling count, and then the block returns to running and clears the enable bit itself.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_o is 0 (running), every clk_en_o bit is 1, core_ldo_en_o is 1, the enable bit, the wake flags and the unlock bit read 0, the idle mask at address 1 reads 0x7E and the power-down mask at address 2 reads 0x70.
- R2: A wait-for-interrupt pulse while running, with the enable bit (address 0, bit 7) clear, moves mode_o to 1 (idle) on the next edge. clk_en_o then equals the idle mask ANDed with 0x7E, so domain 0 (CPU) and domain 7 (window watchdog) are always stopped. Further pulses while idle have no effect.
- R3: While idle, irq_i moves mode_o back to 0 on the next edge, and every clk_en_o bit returns to 1.
- R4: A wait-for-interrupt pulse while running, with the enable bit set and no wake flag pending, moves mode_o to 2 (power-down) on the next edge. clk_en_o then equals the power-down mask ANDed with 0x70 (domains 4 to 6), and core_ldo_en_o is 0.
- R5: A wait-for-interrupt pulse while any wake flag is pending leads to idle (mode_o 1) even when the enable bit is set, never to power-down.
- R6: A pulse on wk_evt_i[i] sets bit i of the flag register at address 3. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: Flag bit 0 (timer interrupt) and flag bit 1 (timer wake) each block power-down on their own, so both must be cleared before entry.
- R8: In power-down, any wk_evt_i pulse moves mode_o to 3 (waking) on the next edge and turns core_ldo_en_o back on, while clk_en_o keeps its power-down value. After exactly WAKE_CYC cycles in waking, mode_o returns to 0 with every clock on and the enable bit cleared.
- R9: Flag bit 8 (watchdog) is cleared only while unlocked. Writing 0xA5, 0x3C and 0xC3 in order to address 4 unlocks, and address 4 bit 0 then reads 1. A wrong key restarts the sequence. Any write to address 3 with bit 8 set closes the window.
- R10: The idle and power-down masks (addresses 1 and 2) read back what was written, but mask bits outside their allow-lists have no effect on clk_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_i | input | 1 | One-cycle wait-for-interrupt pulse from the CPU |
| irq_i | input | 1 | Any enabled interrupt (ends idle) |
| wk_evt_i | input | NFLAG | Per-source wake/interrupt event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DW | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DW | Registered read data |
| clk_en_o | output | NDOM | Per-domain clock-gate enables |
| core_ldo_en_o | output | 1 | Main core regulator enable |
| mode_o | output | 2 | Current mode: 0 running, 1 idle, 2 power-down, 3 waking |

## Verification
Some properties are checked on every cycle: the gating implied by each mode (all clocks on while running, CPU and window watchdog off in idle, only allow-listed domains and the regulator off in power-down), the one-edge exit from idle, the ban on entering power-down while a flag is pending, and the exact length of the waking phase. Other behaviour depends on register history, so only the bench scenarios can show it: the write-1-to-clear flags and their set-over-clear priority, the timer's two blocking flags, the unlock key order and the closing of the window, mask readback, and the automatic clearing of the enable bit.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    M_NORMAL = 2'd0,
    M_IDLE   = 2'd1,
    M_PDOWN  = 2'd2,
    M_WAKE   = 2'd3
  } pmode_e;

  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_IDLE = 3'd1;
  localparam logic [AW-1:0] A_PD   = 3'd2;
  localparam logic [AW-1:0] A_FLAG = 3'd3;
  localparam logic [AW-1:0] A_KEY  = 3'd4;

  localparam int PDEN_BIT     = 7;
  localparam int WDT_FLAG_BIT = 8;

  localparam logic [7:0] KEY0 = 8'hA5;
  localparam logic [7:0] KEY1 = 8'h3C;
  localparam logic [7:0] KEY2 = 8'hC3;
endpackage

// File: rtl/pms_regs.sv
module pms_regs
  import pms_pkg::*;
#(
  parameter int NDOM  = 8,
  parameter int NFLAG = 9,
  parameter int DW    = 16,
  parameter logic [NDOM-1:0] IDLE_RST = 8'h7E,
  parameter logic [NDOM-1:0] PD_RST   = 8'h70
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic [NFLAG-1:0] wk_evt,
  input  logic            pden_clr,
  output logic [DW-1:0]   rd_data,
  output logic            pden,
  output logic [NDOM-1:0] idle_keep,
  output logic [NDOM-1:0] pd_keep,
  output logic            flag_any
);
  logic [NFLAG-1:0] flag_q;
  logic [1:0]       key_step_q;
  logic             unlocked_q;
  logic [DW-1:0]    rd_mux;

  logic wr_ctrl, wr_idle, wr_pd, wr_flag, wr_key, prot_wr;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_idle = wr_en && (wr_addr == A_IDLE);
  assign wr_pd   = wr_en && (wr_addr == A_PD);
  assign wr_flag = wr_en && (wr_addr == A_FLAG);
  assign wr_key  = wr_en && (wr_addr == A_KEY);
  assign prot_wr = wr_flag && wr_data[WDT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pden      <= 1'b0;
      idle_keep <= IDLE_RST;
      pd_keep   <= PD_RST;
    end else begin
      if (pden_clr)     pden <= 1'b0;
      else if (wr_ctrl) pden <= wr_data[PDEN_BIT];
      if (wr_idle) idle_keep <= wr_data[NDOM-1:0];
      if (wr_pd)   pd_keep   <= wr_data[NDOM-1:0];
    end
  end

  // unlock key sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      key_step_q <= 2'd0;
      unlocked_q <= 1'b0;
    end else begin
      if (wr_key) begin
        case (key_step_q)
          2'd0:    key_step_q <= (wr_data == DW'(KEY0)) ? 2'd1 : 2'd0;
          2'd1:    key_step_q <= (wr_data == DW'(KEY1)) ? 2'd2 :
                                 (wr_data == DW'(KEY0)) ? 2'd1 : 2'd0;
          default: key_step_q <= 2'd0;
        endcase
      end
      if (prot_wr)
        unlocked_q <= 1'b0;
      else if (wr_key && key_step_q == 2'd2 && wr_data == DW'(KEY2))
        unlocked_q <= 1'b1;
    end
  end

  // sticky wake flags, write-1-to-clear, set wins
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam bit IS_WDT = (i == WDT_FLAG_BIT);
    logic clr;
    assign clr = wr_flag && wr_data[i] && (!IS_WDT || unlocked_q);
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= wk_evt[i] | (flag_q[i] & ~clr);
    end
  end

  assign flag_any = |flag_q;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_mux = DW'(pden) << PDEN_BIT;
      A_IDLE:  rd_mux = DW'(idle_keep);
      A_PD:    rd_mux = DW'(pd_keep);
      A_FLAG:  rd_mux = DW'(flag_q);
      A_KEY:   rd_mux = DW'(unlocked_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int WAKE_CYC = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wfi,
  input  logic   irq,
  input  logic   pden,
  input  logic   flag_any,
  input  logic   wake_any,
  output pmode_e state_d,
  output logic   pden_clr
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  pmode_e        state_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      M_NORMAL: if (wfi) state_d = (pden && !flag_any) ? M_PDOWN : M_IDLE;
      M_IDLE:   if (irq) state_d = M_NORMAL;
      M_PDOWN:  if (wake_any) state_d = M_WAKE;
      M_WAKE:   if (cnt_q == '0) state_d = M_NORMAL;
      default:  state_d = M_NORMAL;
    endcase
  end

  assign pden_clr = (state_q == M_WAKE) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= M_NORMAL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == M_PDOWN && wake_any)
        cnt_q <= CW'(WAKE_CYC - 1);
      else if (state_q == M_WAKE && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pms_gate.sv
module pms_gate
  import pms_pkg::*;
#(
  parameter int NDOM = 8,
  parameter logic [NDOM-1:0] IDLE_ALLOW = 8'h7E,
  parameter logic [NDOM-1:0] PD_ALLOW   = 8'h70
) (
  input  logic            clk,
  input  logic            rst,
  input  pmode_e          mode_d,
  input  logic [NDOM-1:0] idle_keep,
  input  logic [NDOM-1:0] pd_keep,
  output logic [NDOM-1:0] clk_en,
  output logic            core_on,
  output pmode_e          mode_q
);
  logic run_m, idle_m, low_m;
  assign run_m  = (mode_d == M_NORMAL);
  assign idle_m = (mode_d == M_IDLE);
  assign low_m  = (mode_d == M_PDOWN) || (mode_d == M_WAKE);

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    always_ff @(posedge clk) begin
      if (rst) clk_en[i] <= 1'b1;
      else     clk_en[i] <= run_m
                          | (idle_m & idle_keep[i] & IDLE_ALLOW[i])
                          | (low_m  & pd_keep[i]   & PD_ALLOW[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_on <= 1'b1;
      mode_q  <= M_NORMAL;
    end else begin
      core_on <= (mode_d != M_PDOWN);
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NDOM     = 8,
  parameter int NFLAG    = 9,
  parameter int DW       = 16,
  parameter int WAKE_CYC = 16,
  parameter logic [NDOM-1:0] IDLE_ALLOW = 8'h7E,
  parameter logic [NDOM-1:0] PD_ALLOW   = 8'h70,
  parameter logic [NDOM-1:0] IDLE_RST   = 8'h7E,
  parameter logic [NDOM-1:0] PD_RST     = 8'h70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_i,
  input  logic             irq_i,
  input  logic [NFLAG-1:0] wk_evt_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NDOM-1:0]  clk_en_o,
  output logic             core_ldo_en_o,
  output logic [1:0]       mode_o
);
  logic            pden, pden_clr, flag_any;
  logic [NDOM-1:0] idle_keep, pd_keep;
  pmode_e          state_d, mode_q;

  pms_regs #(
    .NDOM(NDOM), .NFLAG(NFLAG), .DW(DW),
    .IDLE_RST(IDLE_RST), .PD_RST(PD_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .wk_evt(wk_evt_i), .pden_clr(pden_clr),
    .rd_data(rd_data_o), .pden(pden),
    .idle_keep(idle_keep), .pd_keep(pd_keep), .flag_any(flag_any)
  );

  pms_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst(rst),
    .wfi(wfi_i), .irq(irq_i), .pden(pden),
    .flag_any(flag_any), .wake_any(|wk_evt_i),
    .state_d(state_d), .pden_clr(pden_clr)
  );

  pms_gate #(
    .NDOM(NDOM), .IDLE_ALLOW(IDLE_ALLOW), .PD_ALLOW(PD_ALLOW)
  ) u_gate (
    .clk(clk), .rst(rst), .mode_d(state_d),
    .idle_keep(idle_keep), .pd_keep(pd_keep),
    .clk_en(clk_en_o), .core_on(core_ldo_en_o), .mode_q(mode_q)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pms_chk.sv
module pms_chk
  import pms_pkg::*;
#(
  parameter int NDOM     = 8,
  parameter int WAKE_CYC = 16,
  parameter logic [NDOM-1:0] IDLE_ALLOW = 8'h7E,
  parameter logic [NDOM-1:0] PD_ALLOW   = 8'h70
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      mode,
  input logic [NDOM-1:0] clk_en,
  input logic            core_on,
  input logic            irq,
  input logic            flag_any
);
  int unsigned wlen;
  always_ff @(posedge clk) begin
    if (rst)                 wlen <= 0;
    else if (mode == M_WAKE) wlen <= wlen + 1;
    else                     wlen <= 0;
  end

  p_normal_all_on_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == M_NORMAL) |-> (&clk_en && core_on));

  p_idle_cpu_off_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == M_IDLE) |-> ((clk_en & ~IDLE_ALLOW) == '0));

  p_pd_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PDOWN) |-> (((clk_en & ~PD_ALLOW) == '0) && !core_on));

  p_idle_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == M_IDLE && irq) |=> (mode == M_NORMAL));

  p_flag_blocks_pd_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_NORMAL && flag_any) |=> (mode != M_PDOWN));

  p_wake_core_on_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == M_WAKE) |-> (core_on && ((clk_en & ~PD_ALLOW) == '0)));

  p_wake_len_r8: assert property (@(posedge clk) disable iff (rst)
    (mode != M_WAKE && wlen != 0) |-> (wlen == WAKE_CYC));
endmodule

bind pwr_mode_seq pms_chk #(
  .NDOM(NDOM), .WAKE_CYC(WAKE_CYC),
  .IDLE_ALLOW(IDLE_ALLOW), .PD_ALLOW(PD_ALLOW)
) u_pms_chk (
  .clk(clk), .rst(rst), .mode(mode_o), .clk_en(clk_en_o),
  .core_on(core_ldo_en_o), .irq(irq_i), .flag_any(flag_any)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  localparam int WCYC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wfi_i = 1'b0, irq_i = 1'b0, wr_en_i = 1'b0;
  logic [8:0]  wk_evt_i = '0;
  logic [2:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic [7:0]  clk_en_o;
  logic        core_ldo_en_o;
  logic [1:0]  mode_o;

  int nchk = 0, nerr = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  pwr_mode_seq #(.WAKE_CYC(WCYC)) dut (
    .clk(clk), .rst(rst), .wfi_i(wfi_i), .irq_i(irq_i), .wk_evt_i(wk_evt_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .clk_en_o(clk_en_o),
    .core_ldo_en_o(core_ldo_en_o), .mode_o(mode_o)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [15:0] w;
    logic [15:0] e;
  } vec_t;

  // write then read back; R10 masks, R6 flags, R9 key
  localparam vec_t VEC [8] = '{
    '{3'd1, 16'h00FF, 16'h00FF},
    '{3'd2, 16'h0030, 16'h0030},
    '{3'd0, 16'h0080, 16'h0080},
    '{3'd0, 16'h0000, 16'h0000},
    '{3'd3, 16'h00FF, 16'h0000},
    '{3'd4, 16'h0011, 16'h0000},
    '{3'd1, 16'h007E, 16'h007E},
    '{3'd2, 16'h0070, 16'h0070}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr_i = a;
    @(negedge clk); d = rd_data_o;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi_i = 1'b1;
    @(negedge clk); wfi_i = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_i = 1'b1;
    @(negedge clk); irq_i = 1'b0;
  endtask

  task automatic evt(input logic [8:0] m);
    @(negedge clk); wk_evt_i = m;
    @(negedge clk); wk_evt_i = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 mode", mode_o, 0);
    check("R1 clk_en", clk_en_o, 8'hFF);
    check("R1 core ldo", core_ldo_en_o, 1);
    rd(3'd1, v); check("R1 idle mask", v, 16'h007E);
    rd(3'd2, v); check("R1 pd mask", v, 16'h0070);
    rd(3'd3, v); check("R1 flags", v, 0);
    rd(3'd0, v); check("R1 pden", v, 0);
    rd(3'd4, v); check("R1 unlock", v, 0);

    // table walk
    for (int k = 0; k < 8; k++) begin
      wr(VEC[k].a, VEC[k].w);
      rd(VEC[k].a, v);
      check($sformatf("R10/R6/R9 table vector %0d", k), v, VEC[k].e);
    end

    // R2 idle entry and R3 exit
    pulse_wfi();
    check("R2 idle mode", mode_o, 1);
    check("R2 idle clocks", clk_en_o, 8'h7E);
    check("R2 idle ldo", core_ldo_en_o, 1);
    pulse_wfi();
    check("R2 wfi in idle ignored", mode_o, 1);
    pulse_irq();
    check("R3 back to run", mode_o, 0);
    check("R3 clocks on", clk_en_o, 8'hFF);

    // R10 masks limited by allow-lists
    wr(3'd1, 16'h00FF);
    pulse_wfi();
    check("R10 idle mask forced bits", clk_en_o, 8'h7E);
    pulse_irq();
    wr(3'd1, 16'h0030);
    pulse_wfi();
    check("R10 idle mask subset", clk_en_o, 8'h30);
    pulse_irq();
    wr(3'd1, 16'h007E);

    // R6 flag behaviour
    evt(9'h008);
    rd(3'd3, v); check("R6 flag set", v, 16'h0008);
    wr(3'd3, 16'h0000);
    rd(3'd3, v); check("R6 write 0 no effect", v, 16'h0008);
    // R5 pending flag blocks power-down
    wr(3'd0, 16'h0080);
    pulse_wfi();
    check("R5 pending flag -> idle", mode_o, 1);
    check("R5 ldo stays on", core_ldo_en_o, 1);
    pulse_irq();
    wr(3'd3, 16'h0008);
    rd(3'd3, v); check("R6 write 1 clears", v, 0);
    @(negedge clk); wk_evt_i = 9'h008; wr_en_i = 1'b1; wr_addr_i = 3'd3; wr_data_i = 16'h0008;
    @(negedge clk); wk_evt_i = '0; wr_en_i = 1'b0;
    rd(3'd3, v); check("R6 set wins over clear", v, 16'h0008);
    wr(3'd3, 16'h0008);

    // R7 timer flags
    evt(9'h001);
    wr(3'd3, 16'h0002);
    rd(3'd3, v); check("R7 int flag kept", v, 16'h0001);
    pulse_wfi();
    check("R7 int flag blocks", mode_o, 1);
    pulse_irq();
    wr(3'd3, 16'h0001);
    evt(9'h002);
    pulse_wfi();
    check("R7 wake flag blocks", mode_o, 1);
    pulse_irq();
    wr(3'd3, 16'h0002);
    rd(3'd3, v); check("R7 flags clear", v, 0);

    // R4 power-down, R10 pd mask limit
    wr(3'd2, 16'h00FF);
    pulse_wfi();
    check("R4 pd mode", mode_o, 2);
    check("R4 pd clocks", clk_en_o, 8'h70);
    check("R4 ldo off", core_ldo_en_o, 0);
    irq_i = 1'b1; @(negedge clk); irq_i = 1'b0;
    check("R8 irq alone does not wake", mode_o, 2);

    // R8 wake sequence
    evt(9'h010);
    check("R8 waking", mode_o, 3);
    check("R8 ldo on", core_ldo_en_o, 1);
    check("R8 clocks still gated", clk_en_o, 8'h70);
    repeat (WCYC - 1) @(negedge clk);
    check("R8 still waking at last cycle", mode_o, 3);
    @(negedge clk);
    check("R8 back to run", mode_o, 0);
    check("R8 clocks on", clk_en_o, 8'hFF);
    rd(3'd0, v); check("R8 pden cleared", v, 0);
    rd(3'd3, v); check("R8 flag latched", v, 16'h0010);
    wr(3'd3, 16'h0010);
    wr(3'd2, 16'h0070);

    // R9 watchdog flag protection
    evt(9'h100);
    wr(3'd3, 16'h0100);
    rd(3'd3, v); check("R9 locked clear ignored", v, 16'h0100);
    wr(3'd4, 16'h00A5); wr(3'd4, 16'h0077); wr(3'd4, 16'h00C3);
    rd(3'd4, v); check("R9 wrong key stays locked", v, 0);
    wr(3'd4, 16'h00A5); wr(3'd4, 16'h003C); wr(3'd4, 16'h00C3);
    rd(3'd4, v); check("R9 unlocked", v, 1);
    wr(3'd3, 16'h0100);
    rd(3'd3, v); check("R9 unlocked clear", v, 0);
    rd(3'd4, v); check("R9 window closed", v, 0);
    evt(9'h100);
    wr(3'd3, 16'h0100);
    rd(3'd3, v); check("R9 relocked clear ignored", v, 16'h0100);

    finish_run();
  end
endmodule